// File: doc/BRIEF.md
# Address Window Decoder

This block takes a bus address and checks it against a small set of programmable address windows. Each window has a base value, a mask, a translation value and two control bits: a space select (memory or IO) and a translation enable. Only a fixed number of the most significant address bits take part in the compare. A mask bit of 1 makes the matching address bit count in the compare. A mask bit of 0 leaves that bit out, which makes the window larger. A window whose mask is all zeros is switched off.

A request enters through a valid/ready handshake and carries an address, a space flag and a wait-state select of 1, 2 or 3 cycles. The result is computed from the window registers as they stood in the acceptance cycle. It is then presented after exactly the selected number of wait states. The result is a one-hot hit vector, a window number and the output address. When the winning window has translation enabled, the masked upper bits of the output address come from that window's translation value. The result stays on the outputs until the consumer takes it. Window 1 is always built. Windows 2 to 5 are each enabled by a parameter. A write port rewrites one field of one window per clock.

Top module: `addr_win_dec`

## Requirements
- R1: After reset, `in_ready_o` is 1 and `out_valid_o` is 0.
- R2: A window hits when, for every compared upper address bit (address bits 31..12 by default) whose mask bit is 1, the address bit equals the base bit. The low address bits never affect the hit.
- R3: Compared bits whose mask bit is 0 are ignored. A window whose mask is all zeros never hits.
- R4: A window hits only if `in_io_i` equals its space bit. The space bit is bit 0 of the control field, with 1 meaning IO and 0 meaning memory.
- R5: If several windows hit, the lowest-numbered one wins. `out_hitv_o` is one-hot, with bit n-1 standing for window n. `out_idx_o` gives the window number 1..5, or 0 on a miss, with `out_hit_o` 0 on a miss.
- R6: When translation is built in (`XLAT_IMPL`=1) and the winner's translation enable (control bit 1) is set, each masked upper address bit is replaced by the translation bit. All other bits pass through unchanged. On a miss, or with the enable clear, the address passes through unchanged.
- R7: When `XLAT_IMPL`=0, the output address always equals the input address, whatever the enable bits say.
- R8: `out_valid_o` rises exactly N clock edges after the accepting edge. N is the value of `ws_sel_i` at acceptance (1, 2 or 3), and a value of 0 is treated as 1.
- R9: Only one request is in flight at a time. `in_ready_o` is 0 from acceptance until the result handshake. While `out_valid_o` is 1 and `out_ready_i` is 0, all result outputs hold their values.
- R10: With `cfg_we_i` set, field `cfg_fld_i` (0 base, 1 mask, 2 translation, 3 control) of window number `cfg_win_i` takes `cfg_data_i`. A write to a window that is not built is ignored, and such a window never hits.
- R11: A request is decoded with the register values from before any write made in its acceptance cycle. That write takes effect for the next request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Block idle, request accepted |
| in_addr_i | input | ADDR_W | Request address |
| in_io_i | input | 1 | Request space: 1 IO, 0 memory |
| ws_sel_i | input | 2 | Wait states for this request (0/1, 2, 3) |
| cfg_we_i | input | 1 | Register write strobe |
| cfg_win_i | input | IDX_W | Window number to write (1..NUM_WIN) |
| cfg_fld_i | input | 2 | Field: 0 base, 1 mask, 2 translation, 3 control |
| cfg_data_i | input | CMP_BITS | Write data; control uses bit 1 enable, bit 0 IO |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Result taken |
| out_hit_o | output | 1 | Some window hit |
| out_hitv_o | output | NUM_WIN | One-hot winning window |
| out_idx_o | output | IDX_W | Winning window number, 0 on miss |
| out_addr_o | output | ADDR_W | Output address, translated if enabled |

## Verification
The result of a request accepted at edge k is due after edge k+N, where N is the effective wait-state count. The bench's cycle model advances its own state at every rising edge and compares ready, valid and, when valid, every result output on the following falling edge. A wrong latency therefore shows up in the exact cycle where it occurs. Directed requests also measure the latency from the acceptance edge to the first falling edge that sees `out_valid_o`, and check the hit, window number and address captured there against values worked out by hand.

// File: rtl/addr_win_pkg.sv
package addr_win_pkg;
  typedef enum logic [1:0] {
    FLD_BASE = 2'd0,
    FLD_MASK = 2'd1,
    FLD_XLAT = 2'd2,
    FLD_CTRL = 2'd3
  } fld_e;

  typedef struct packed {
    logic xen;
    logic io;
  } ctrl_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } seq_e;
endpackage

// File: rtl/win_regs.sv
module win_regs
  import addr_win_pkg::*;
#(
  parameter int CMP_BITS = 20,
  parameter logic [CMP_BITS-1:0] BASE_RST = '0,
  parameter logic [CMP_BITS-1:0] MASK_RST = '0,
  parameter logic [CMP_BITS-1:0] XLAT_RST = '0,
  parameter logic [1:0] CTRL_RST = '0
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [1:0]          fld_i,
  input  logic [CMP_BITS-1:0] data_i,
  output logic [CMP_BITS-1:0] base_o,
  output logic [CMP_BITS-1:0] mask_o,
  output logic [CMP_BITS-1:0] xlat_o,
  output ctrl_t               ctrl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_o <= BASE_RST;
      mask_o <= MASK_RST;
      xlat_o <= XLAT_RST;
      ctrl_o <= ctrl_t'(CTRL_RST);
    end else if (we_i) begin
      case (fld_e'(fld_i))
        FLD_BASE: base_o <= data_i;
        FLD_MASK: mask_o <= data_i;
        FLD_XLAT: xlat_o <= data_i;
        default:  ctrl_o <= ctrl_t'(data_i[1:0]);
      endcase
    end
  end

  // R10: a mask write lands on the next edge
  assert_wr_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && fld_i == 2'd1) |=> (mask_o == $past(data_i)));
  assert_wr_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> ($stable(base_o) && $stable(mask_o) && $stable(xlat_o)));
endmodule

// File: rtl/win_match.sv
module win_match
  import addr_win_pkg::*;
#(
  parameter int CMP_BITS  = 20,
  parameter int XLAT_IMPL = 1
) (
  input  logic [CMP_BITS-1:0] addr_hi_i,
  input  logic                io_i,
  input  logic [CMP_BITS-1:0] base_i,
  input  logic [CMP_BITS-1:0] mask_i,
  input  logic [CMP_BITS-1:0] xlat_i,
  input  ctrl_t               ctrl_i,
  output logic                hit_o,
  output logic [CMP_BITS-1:0] xaddr_o
);
  logic enabled, bits_eq, space_eq;

  assign enabled  = |mask_i;
  assign bits_eq  = ((addr_hi_i ^ base_i) & mask_i) == '0;
  assign space_eq = io_i == ctrl_i.io;
  assign hit_o    = enabled && bits_eq && space_eq;

  assign xaddr_o = (XLAT_IMPL != 0 && ctrl_i.xen)
                   ? ((addr_hi_i & ~mask_i) | (xlat_i & mask_i))
                   : addr_hi_i;

  // R3: all-zero mask never hits
  assert_off_nohit_R3: assert final (!(mask_i == '0 && hit_o));
endmodule

// File: rtl/prio_sel.sv
module prio_sel #(
  parameter int NUM_WIN  = 5,
  parameter int CMP_BITS = 20,
  localparam int IDX_W   = $clog2(NUM_WIN + 1)
) (
  input  logic [NUM_WIN-1:0]  hit_i,
  input  logic [CMP_BITS-1:0] xaddr_i [NUM_WIN],
  output logic                any_o,
  output logic [NUM_WIN-1:0]  hitv_o,
  output logic [IDX_W-1:0]    idx_o,
  output logic [CMP_BITS-1:0] xaddr_o
);
  // descending scan so the lowest window is written last and wins
  always_comb begin
    any_o   = 1'b0;
    hitv_o  = '0;
    idx_o   = '0;
    xaddr_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (hit_i[i]) begin
        any_o     = 1'b1;
        hitv_o    = '0;
        hitv_o[i] = 1'b1;
        idx_o     = IDX_W'(i + 1);
        xaddr_o   = xaddr_i[i];
      end
    end
  end

  // R5
  assert_onehot_sel_R5: assert final ($onehot0(hitv_o));
endmodule

// File: rtl/addr_win_dec.sv
module addr_win_dec
  import addr_win_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int CMP_BITS  = 20,
  parameter int NUM_WIN   = 5,
  parameter int XLAT_IMPL = 1,
  parameter logic [NUM_WIN-1:0] WIN_PRESENT = 5'b00011,
  parameter logic [NUM_WIN*CMP_BITS-1:0] BASE_RST =
    {20'h00000, 20'h00000, 20'h00000, 20'h80000, 20'h00000},
  parameter logic [NUM_WIN*CMP_BITS-1:0] MASK_RST =
    {20'h00000, 20'h00000, 20'h00000, 20'h80000, 20'h80000},
  parameter logic [NUM_WIN*CMP_BITS-1:0] XLAT_RST = '0,
  parameter logic [NUM_WIN*2-1:0] CTRL_RST = '0,
  localparam int IDX_W = $clog2(NUM_WIN + 1),
  localparam int LO_W  = ADDR_W - CMP_BITS
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                in_valid_i,
  output logic                in_ready_o,
  input  logic [ADDR_W-1:0]   in_addr_i,
  input  logic                in_io_i,
  input  logic [1:0]          ws_sel_i,
  input  logic                cfg_we_i,
  input  logic [IDX_W-1:0]    cfg_win_i,
  input  logic [1:0]          cfg_fld_i,
  input  logic [CMP_BITS-1:0] cfg_data_i,
  output logic                out_valid_o,
  input  logic                out_ready_i,
  output logic                out_hit_o,
  output logic [NUM_WIN-1:0]  out_hitv_o,
  output logic [IDX_W-1:0]    out_idx_o,
  output logic [ADDR_W-1:0]   out_addr_o
);
  logic [CMP_BITS-1:0] addr_hi;
  logic [LO_W-1:0]     addr_lo;
  assign addr_hi = in_addr_i[ADDR_W-1 -: CMP_BITS];
  assign addr_lo = in_addr_i[LO_W-1:0];

  logic [CMP_BITS-1:0] base  [NUM_WIN];
  logic [CMP_BITS-1:0] mask  [NUM_WIN];
  logic [CMP_BITS-1:0] xlat  [NUM_WIN];
  logic [CMP_BITS-1:0] xaddr [NUM_WIN];
  ctrl_t               ctrl  [NUM_WIN];
  logic [NUM_WIN-1:0]  hit;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam bit PRES = (w == 0) || WIN_PRESENT[w];
    if (PRES) begin : g_on
      win_regs #(
        .CMP_BITS (CMP_BITS),
        .BASE_RST (BASE_RST[w*CMP_BITS +: CMP_BITS]),
        .MASK_RST (MASK_RST[w*CMP_BITS +: CMP_BITS]),
        .XLAT_RST (XLAT_RST[w*CMP_BITS +: CMP_BITS]),
        .CTRL_RST (CTRL_RST[w*2 +: 2])
      ) u_regs (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .we_i   (cfg_we_i && (cfg_win_i == IDX_W'(w + 1))),
        .fld_i  (cfg_fld_i),
        .data_i (cfg_data_i),
        .base_o (base[w]),
        .mask_o (mask[w]),
        .xlat_o (xlat[w]),
        .ctrl_o (ctrl[w])
      );
    end else begin : g_off
      assign base[w] = '0;
      assign mask[w] = '0;
      assign xlat[w] = '0;
      assign ctrl[w] = '0;
    end

    win_match #(
      .CMP_BITS  (CMP_BITS),
      .XLAT_IMPL (XLAT_IMPL)
    ) u_match (
      .addr_hi_i (addr_hi),
      .io_i      (in_io_i),
      .base_i    (base[w]),
      .mask_i    (mask[w]),
      .xlat_i    (xlat[w]),
      .ctrl_i    (ctrl[w]),
      .hit_o     (hit[w]),
      .xaddr_o   (xaddr[w])
    );
  end

  logic                sel_any;
  logic [NUM_WIN-1:0]  sel_hitv;
  logic [IDX_W-1:0]    sel_idx;
  logic [CMP_BITS-1:0] sel_xaddr;

  prio_sel #(
    .NUM_WIN  (NUM_WIN),
    .CMP_BITS (CMP_BITS)
  ) u_prio (
    .hit_i   (hit),
    .xaddr_i (xaddr),
    .any_o   (sel_any),
    .hitv_o  (sel_hitv),
    .idx_o   (sel_idx),
    .xaddr_o (sel_xaddr)
  );

  seq_e               state;
  logic [1:0]         cnt;
  logic               r_hit;
  logic [NUM_WIN-1:0] r_hitv;
  logic [IDX_W-1:0]   r_idx;
  logic [ADDR_W-1:0]  r_addr;

  // result snapshot taken at acceptance, then held through the wait states
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state  <= ST_IDLE;
      cnt    <= '0;
      r_hit  <= 1'b0;
      r_hitv <= '0;
      r_idx  <= '0;
      r_addr <= '0;
    end else begin
      case (state)
        ST_IDLE: if (in_valid_i) begin
          state  <= ST_WAIT;
          cnt    <= (ws_sel_i == 2'd0) ? 2'd0 : ws_sel_i - 2'd1;
          r_hit  <= sel_any;
          r_hitv <= sel_hitv;
          r_idx  <= sel_idx;
          r_addr <= {(sel_any ? sel_xaddr : addr_hi), addr_lo};
        end
        ST_WAIT: begin
          if (cnt == 2'd0) state <= ST_DONE;
          else             cnt   <= cnt - 2'd1;
        end
        ST_DONE: if (out_ready_i) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign in_ready_o  = state == ST_IDLE;
  assign out_valid_o = state == ST_DONE;
  assign out_hit_o   = r_hit;
  assign out_hitv_o  = r_hitv;
  assign out_idx_o   = r_idx;
  assign out_addr_o  = r_addr;

  // checker-side tracking of latency and raw request address
  logic [2:0]        chk_lat;
  logic [1:0]        chk_ws;
  logic [ADDR_W-1:0] chk_addr;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_lat  <= '0;
      chk_ws   <= 2'd1;
      chk_addr <= '0;
    end else if (in_valid_i && in_ready_o) begin
      chk_lat  <= '0;
      chk_ws   <= (ws_sel_i == 2'd0) ? 2'd1 : ws_sel_i;
      chk_addr <= in_addr_i;
    end else if (!in_ready_o) begin
      chk_lat  <= chk_lat + 3'd1;
    end
  end

  assert_latency_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(out_valid_o) |-> (chk_lat == {1'b0, chk_ws}));
  assert_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(in_ready_o && out_valid_o));
  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_addr_o) && $stable(out_hitv_o) && $stable(out_idx_o)));
  assert_onehot_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> ($onehot0(out_hitv_o) && (out_hit_o == (out_idx_o != '0))));
  assert_miss_pass_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_hit_o) |-> (out_addr_o == chk_addr));
  assert_low_pass_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_addr_o[LO_W-1:0] == chk_addr[LO_W-1:0]));
endmodule

// File: tb/sim_addr_win_dec.sv
module sim_addr_win_dec;
  localparam int CLK_NS = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [31:0] in_addr_i = '0;
  logic        in_io_i = 1'b0;
  logic [1:0]  ws_sel_i = 2'd1;
  logic        cfg_we_i = 1'b0;
  logic [2:0]  cfg_win_i = '0;
  logic [1:0]  cfg_fld_i = '0;
  logic [19:0] cfg_data_i = '0;
  logic        out_ready_i = 1'b0;
  logic        in_ready_o, out_valid_o, out_hit_o;
  logic [4:0]  out_hitv_o;
  logic [2:0]  out_idx_o;
  logic [31:0] out_addr_o;
  logic        n_ready, n_valid, n_hit;
  logic [4:0]  n_hitv;
  logic [2:0]  n_idx;
  logic [31:0] n_addr;

  always #(CLK_NS / 2) clk_i = ~clk_i;

  addr_win_dec u0 (.*);

  addr_win_dec #(.XLAT_IMPL(0)) u1 (
    .clk_i, .rst_ni, .in_valid_i, .in_ready_o(n_ready), .in_addr_i, .in_io_i,
    .ws_sel_i, .cfg_we_i, .cfg_win_i, .cfg_fld_i, .cfg_data_i,
    .out_valid_o(n_valid), .out_ready_i, .out_hit_o(n_hit), .out_hitv_o(n_hitv),
    .out_idx_o(n_idx), .out_addr_o(n_addr)
  );

  int nchk = 0, nbad = 0;
  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [19:0] mb[5], mm[5], mx[5];
  logic [1:0]  mc[5];
  logic [4:0]  mp = 5'b00011;
  int          m_st, m_cnt;
  logic [4:0]  m_hitv;
  int          m_idx;
  logic [31:0] m_xa, m_raw;

  task automatic m_reset();
    foreach (mb[i]) begin mb[i] = '0; mm[i] = '0; mx[i] = '0; mc[i] = '0; end
    mm[0] = 20'h80000; mm[1] = 20'h80000; mb[1] = 20'h80000;
    m_st = 0; m_cnt = 0; m_hitv = '0; m_idx = 0; m_xa = '0; m_raw = '0;
  endtask

  task automatic m_decode(logic [31:0] a, logic io);
    m_hitv = '0; m_idx = 0; m_xa = a; m_raw = a;
    for (int w = 0; w < 5; w++) begin
      if (m_idx == 0 && mp[w] && mm[w] != 0 &&
          ((a[31:12] ^ mb[w]) & mm[w]) == 0 && io == mc[w][0]) begin
        m_idx = w + 1;
        m_hitv[w] = 1'b1;
        if (mc[w][1]) m_xa[31:12] = (a[31:12] & ~mm[w]) | (mx[w] & mm[w]);
      end
    end
  endtask

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) m_reset();
    else begin
      if (m_st == 2) begin
        if (out_ready_i) m_st = 0;
      end else if (m_st == 1) begin
        if (m_cnt == 0) m_st = 2; else m_cnt--;
      end else if (in_valid_i) begin
        m_decode(in_addr_i, in_io_i);
        m_st = 1;
        m_cnt = (ws_sel_i == 0) ? 0 : int'(ws_sel_i) - 1;
      end
      if (cfg_we_i && cfg_win_i >= 1 && cfg_win_i <= 5 && mp[cfg_win_i-1]) begin
        case (cfg_fld_i)
          2'd0: mb[cfg_win_i-1] = cfg_data_i;
          2'd1: mm[cfg_win_i-1] = cfg_data_i;
          2'd2: mx[cfg_win_i-1] = cfg_data_i;
          default: mc[cfg_win_i-1] = cfg_data_i[1:0];
        endcase
      end
    end
  end

  always @(negedge clk_i) begin
    if (rst_ni) begin
      chk("R9 in_ready per cycle", in_ready_o, m_st == 0);
      chk("R8 out_valid per cycle", out_valid_o, m_st == 2);
      chk("R7 u1 out_valid per cycle", n_valid, m_st == 2);
      if (m_st == 2) begin
        chk("R5 hit vector", out_hitv_o, m_hitv);
        chk("R5 window number", out_idx_o, m_idx);
        chk("R2 hit flag", out_hit_o, m_idx != 0);
        chk("R6 output address", out_addr_o, m_xa);
        chk("R7 untranslated address", n_addr, m_raw);
      end
    end
  end

  task automatic cfg(int win, int fld, logic [19:0] d);
    @(negedge clk_i);
    cfg_we_i = 1'b1; cfg_win_i = 3'(win); cfg_fld_i = 2'(fld); cfg_data_i = d;
    @(negedge clk_i);
    cfg_we_i = 1'b0;
  endtask

  int          r_lat, r_idx;
  logic [4:0]  r_hitv;
  logic [31:0] r_addr, r_addr1;

  task automatic req(logic [31:0] a, logic io, int ws, int hold,
                     int wwin = 0, int wfld = 0, logic [19:0] wdat = '0);
    int n;
    @(negedge clk_i);
    in_valid_i = 1'b1; in_addr_i = a; in_io_i = io; ws_sel_i = 2'(ws);
    if (wwin != 0) begin
      cfg_we_i = 1'b1; cfg_win_i = 3'(wwin); cfg_fld_i = 2'(wfld); cfg_data_i = wdat;
    end
    @(negedge clk_i);
    in_valid_i = 1'b0; cfg_we_i = 1'b0;
    n = 1;
    while (!out_valid_o) begin @(negedge clk_i); n++; end
    r_lat = n - 1; r_idx = int'(out_idx_o); r_hitv = out_hitv_o;
    r_addr = out_addr_o; r_addr1 = n_addr;
    if (hold > 0) begin
      in_valid_i = 1'b1; in_addr_i = 32'hFFFF_FFFF;
      for (int i = 0; i < hold; i++) begin
        @(negedge clk_i);
        chk("R9 valid held", out_valid_o, 1'b1);
        chk("R9 no second accept", in_ready_o, 1'b0);
        chk("R9 address held", out_addr_o, r_addr);
      end
      in_valid_i = 1'b0;
    end
    out_ready_i = 1'b1;
    @(negedge clk_i);
    out_ready_i = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    nbad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk("R1 reset ready", in_ready_o, 1'b1);
    chk("R1 reset valid", out_valid_o, 1'b0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 ready after reset", in_ready_o, 1'b1);

    // R2 default windows, with R9 hold
    req(32'h1234_5678, 1'b0, 1, 3);
    chk("R2 w1 hit", r_idx, 1); chk("R8 latency 1", r_lat, 1);
    chk("R2 addr unchanged", r_addr, 32'h1234_5678);
    req(32'h9000_0000, 1'b0, 2, 0);
    chk("R2 w2 hit", r_idx, 2); chk("R5 hitv w2", r_hitv, 5'b00010);
    chk("R8 latency 2", r_lat, 2);
    // R4 space mismatch
    req(32'h1234_5678, 1'b1, 3, 0);
    chk("R4 io miss", r_idx, 0); chk("R8 latency 3", r_lat, 3);
    chk("R4 miss addr", r_addr, 32'h1234_5678);
    req(32'h0000_0000, 1'b0, 0, 0);
    chk("R8 zero select is 1", r_lat, 1); chk("R2 low addr hit", r_idx, 1);

    // R10 register writes
    cfg(2, 0, 20'hABCDE); cfg(2, 1, 20'hFFFFF);
    req(32'hABCD_E123, 1'b0, 1, 0);
    chk("R10 written window hit", r_idx, 2);
    req(32'hABCD_F123, 1'b0, 1, 0);
    chk("R10 full mask miss", r_idx, 0);

    // R3 unmasked bits ignored, zero mask off
    cfg(2, 1, 20'hFFF00); cfg(2, 0, 20'hABC00);
    req(32'hABCF_F000, 1'b0, 2, 0);
    chk("R3 unmasked ignored", r_idx, 2);
    cfg(1, 1, 20'h00000);
    req(32'h0000_0000, 1'b0, 1, 0);
    chk("R3 zero mask never hits", r_idx, 0);

    // R5 priority
    cfg(1, 1, 20'h80000); cfg(2, 0, 20'h00000); cfg(2, 1, 20'h40000);
    req(32'h1000_0000, 1'b0, 1, 0);
    chk("R5 lowest wins", r_idx, 1); chk("R5 one-hot", r_hitv, 5'b00001);
    req(32'h8000_0000, 1'b0, 1, 0);
    chk("R5 second window", r_idx, 2);

    // R6 / R7 translation
    cfg(1, 1, 20'h00000);
    cfg(2, 0, 20'h30000); cfg(2, 1, 20'hF0000); cfg(2, 2, 20'hA5555); cfg(2, 3, 20'h2);
    req(32'h3123_4567, 1'b0, 2, 0);
    chk("R6 translated", r_addr, 32'hA123_4567);
    chk("R7 no translation built", r_addr1, 32'h3123_4567);
    cfg(2, 3, 20'h3);
    req(32'h3123_4567, 1'b1, 3, 0);
    chk("R6 io translated", r_addr, 32'hA123_4567);
    req(32'h3123_4567, 1'b0, 1, 0);
    chk("R4 memory vs io window", r_idx, 0);
    chk("R6 miss passthrough", r_addr, 32'h3123_4567);

    // R10 absent window
    cfg(3, 0, 20'h77777); cfg(3, 1, 20'hFFFFF);
    req(32'h7777_7000, 1'b0, 1, 0);
    chk("R10 absent window ignored", r_idx, 0);

    // R11 write in acceptance cycle
    req(32'h3123_4567, 1'b1, 2, 0, 2, 1, 20'h00000);
    chk("R11 old registers used", r_idx, 2);
    chk("R11 old translation", r_addr, 32'hA123_4567);
    req(32'h3123_4567, 1'b1, 2, 0);
    chk("R11 write applies next", r_idx, 0);

    repeat (2) @(negedge clk_i);
    $display("  test done: total=%0d bad=%0d", nchk, nbad);
    $finish;
  end
endmodule